// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block is a two-channel direct memory access engine. It copies data from memory to memory, from a port to memory, or from a port to another port, over a simple single-master bus. Each channel keeps its own source pointer, destination pointer, unit count and mode. A run starts in one of two ways: a software write sets the start bit, or the channel's own request line rises. A shared engine moves one unit at a time. It asks for the bus, reads one unit and then writes it back. When both channels are waiting, an arbiter chooses between them, using either fixed priority or round-robin priority.

The engine is a four-state machine:
- `ENG_IDLE` goes to `ENG_REQ` when any channel is active. The arbiter's choice is latched on this transition.
- `ENG_REQ` goes to `ENG_RD` once `bus_gnt` is high.
- `ENG_RD` always goes to `ENG_WR`. On this transition the read data is latched.
- `ENG_WR` goes back to `ENG_RD` when the channel is in burst mode and units remain. Otherwise it returns to `ENG_IDLE`, which releases the bus.

Every channel raises its own maskable interrupt when its run ends or when its start is refused with an error.

The configuration port writes one register per cycle. `cfg_ch` picks the channel and `cfg_sel` picks the register:

| `cfg_sel` | Register |
|---|---|
| 0 | Source address |
| 1 | Destination address |
| 2 | Count |
| 3 | Mode |
| 4 | Control |
| 5 | Global (ignores `cfg_ch`) |

Top module: `dma2_top`

## Requirements
- R1: After reset, `bus_req`, `irq`, `err_flag` and `busy` are all zero.
- R2: Mode bits [1:0] select the unit size: 0 is a byte, 1 is a halfword and 2 is a word. Data is right-justified on `mem_rdata`/`mem_wdata`. Without hold bits, both addresses advance by 1, 2 or 4 after each unit.
- R3: Global register bit 0 set to 0 selects fixed priority. In that mode, when both channels are active, channel 0 is served before channel 1 at every arbitration.
- R4: Global bit 0 set to 1 selects round-robin priority. When both channels are active, the channel served last loses the next arbitration, so units alternate.
- R5: A count register value of C performs exactly C+1 units. A value of 0 performs one unit, and 0xFFFF performs 65,536 units.
- R6: Mode bit 3 holds the source address fixed and mode bit 4 holds the destination address fixed for the whole run.
- R7: With mode bit 2 clear (cycle-steal), `bus_req` drops after every unit, and the engine arbitrates again before the next unit.
- R8: With mode bit 2 set (burst), `bus_req` stays high from the first unit until the last unit of the run.
- R9: A start is refused with a sticky error in either of these cases: the size field is 3, or the source or destination address is not a multiple of the unit size. A refused start makes no bus access. While the error is set, further starts are ignored. Writing control bit 1 clears the error.
- R10: `irq[n]` is high when channel n has its done flag or its error flag set and its mode bit 5 is set. The done flag is set when a run completes and is cleared by writing control bit 2.
- R11: Writing control bit 0 starts an idle channel. So does a rising edge on `dreq[n]` when mode bit 6 of that channel is set.
- R12: `mem_re` and `mem_we` are never both high. They are asserted only while `bus_req` is high and granted, with one read cycle followed by one write cycle per unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | 2 | Per-channel external request lines |
| bus_gnt | input | 1 | Bus grant, held high while granted |
| mem_rdata | input | 32 | Read data, right-justified |
| bus_req | output | 1 | Bus request |
| mem_addr | output | 32 | Byte address of the current access |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_size | output | 2 | Size code of the current access |
| mem_wdata | output | 32 | Write data, right-justified |
| irq | output | 2 | Per-channel interrupt |
| err_flag | output | 2 | Per-channel sticky error |
| busy | output | 2 | Channel run in progress |

## Verification
Some behaviours are checked by assertions on every cycle:
- The read and write strobes exclude each other and only appear under a granted request.
- A burst unit with units remaining keeps the request high, and a cycle-steal unit drops it.
- A run ends exactly when its last unit is written.
- The interrupt never rises without a done or error cause.
- The arbiter never selects a channel that is not requesting, and its choice follows the fixed or rotating rule.

Other behaviours only the bench scenarios can show:
- The data actually landing at the right addresses for each size and hold setting.
- The service order seen at the bus when both request lines rise in the same cycle.
- Refused starts leaving memory untouched.
- The mask bit gating an already-set done flag.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_RD   = 2'd2,
        ENG_WR   = 2'd3
    } eng_state_e;

    typedef enum logic [2:0] {
        REG_SRC    = 3'd0,
        REG_DST    = 3'd1,
        REG_CNT    = 3'd2,
        REG_MODE   = 3'd3,
        REG_CTRL   = 3'd4,
        REG_GLOBAL = 3'd5
    } reg_sel_e;

    // mode register bit positions
    localparam int MB_BURST = 2;
    localparam int MB_SHOLD = 3;
    localparam int MB_DHOLD = 4;
    localparam int MB_IEN   = 5;
    localparam int MB_EXT   = 6;
    localparam int MODE_W   = 7;

    // control register bit positions
    localparam int CB_START   = 0;
    localparam int CB_CLR_ERR = 1;
    localparam int CB_CLR_DON = 2;

    // address low bits that must be zero for a given size code
    function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 1'b0;
            2'd1:    return lo[0];
            default: return lo != 2'b00;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hit,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              dreq,
    input  logic              unit_done,
    output logic              active,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [1:0]        size,
    output logic              burst,
    output logic              last,
    output logic              irq,
    output logic              err_flag
);

    logic [ADDR_W-1:0] src_q, dst_q, step;
    logic [CNT_W-1:0]  cnt_q, rem_q;
    logic [MODE_W-1:0] mode_q;
    logic              active_q, done_q, err_q, dreq_q;
    logic              cfg_open, sw_start, ext_start, start, bad, clr_err, clr_done;

    // configuration is only accepted while no run is in flight
    always_comb begin
        cfg_open  = cfg_hit && !active_q;
        sw_start  = cfg_hit && (cfg_sel == REG_CTRL) && cfg_wdata[CB_START];
        clr_err   = cfg_hit && (cfg_sel == REG_CTRL) && cfg_wdata[CB_CLR_ERR];
        clr_done  = cfg_hit && (cfg_sel == REG_CTRL) && cfg_wdata[CB_CLR_DON];
        ext_start = mode_q[MB_EXT] && dreq && !dreq_q;
        start     = (sw_start || ext_start) && !active_q && !err_q;
        bad       = (mode_q[1:0] == 2'd3)
                  || misaligned(src_q[1:0], mode_q[1:0])
                  || misaligned(dst_q[1:0], mode_q[1:0]);
        step      = ADDR_W'(1) << mode_q[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            rem_q    <= '0;
            mode_q   <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            dreq_q   <= 1'b0;
        end else begin
            dreq_q <= dreq;
            if (cfg_open && cfg_sel == REG_SRC)  src_q  <= ADDR_W'(cfg_wdata);
            if (cfg_open && cfg_sel == REG_DST)  dst_q  <= ADDR_W'(cfg_wdata);
            if (cfg_open && cfg_sel == REG_CNT)  cnt_q  <= CNT_W'(cfg_wdata);
            if (cfg_open && cfg_sel == REG_MODE) mode_q <= cfg_wdata[MODE_W-1:0];
            if (clr_err)  err_q  <= 1'b0;
            if (clr_done) done_q <= 1'b0;
            if (start) begin
                if (bad) begin
                    err_q <= 1'b1;
                end else begin
                    active_q <= 1'b1;
                    cur_src  <= src_q;
                    cur_dst  <= dst_q;
                    rem_q    <= cnt_q;
                end
            end else if (active_q && unit_done) begin
                if (rem_q == '0) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    rem_q <= rem_q - 1'b1;
                    if (!mode_q[MB_SHOLD]) cur_src <= cur_src + step;
                    if (!mode_q[MB_DHOLD]) cur_dst <= cur_dst + step;
                end
            end
        end
    end

    always_comb begin
        active   = active_q;
        size     = mode_q[1:0];
        burst    = mode_q[MB_BURST];
        last     = (rem_q == '0);
        err_flag = err_q;
        irq      = (done_q || err_q) && mode_q[MB_IEN];
    end

    // R5
    count_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && unit_done && rem_q == '0) |=> (!active_q && done_q));

    // R9
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && $past(err_q)) |-> !$rose(active_q));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (done_q || err_q));

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    input  logic           rr_mode,
    input  logic           take,
    output logic           pick
);

    logic last_q;

    always_comb begin
        if (req == 2'b11) pick = rr_mode ? ~last_q : 1'b0;
        else              pick = req[1] & ~req[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= 1'b1;
        else if (take) last_q <= pick;
    end

    // R3
    fixed_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rr_mode && req[0]) |-> (pick == 1'b0));

    // R4
    rr_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rr_mode && req == 2'b11) |-> (pick != last_q));

    // R12
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> req[pick]);

endmodule

// File: rtl/dma2_eng.sv
module dma2_eng
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             ch_req,
    input  logic                       pick,
    input  logic [NCH-1:0][ADDR_W-1:0] ch_src,
    input  logic [NCH-1:0][ADDR_W-1:0] ch_dst,
    input  logic [NCH-1:0][1:0]        ch_size,
    input  logic [NCH-1:0]             ch_burst,
    input  logic [NCH-1:0]             ch_last,
    input  logic                       bus_gnt,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic                       take,
    output logic [NCH-1:0]             unit_done,
    output logic                       bus_req,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_re,
    output logic                       mem_we,
    output logic [1:0]                 mem_size,
    output logic [DATA_W-1:0]          mem_wdata
);

    eng_state_e        state;
    logic              sel_q;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            sel_q  <= 1'b0;
            data_q <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: if (|ch_req) begin
                    state <= ENG_REQ;
                    sel_q <= pick;
                end
                ENG_REQ: if (bus_gnt) state <= ENG_RD;
                ENG_RD: begin
                    state  <= ENG_WR;
                    data_q <= mem_rdata & DATA_W'(lane_mask(ch_size[sel_q]));
                end
                ENG_WR: state <= (ch_burst[sel_q] && !ch_last[sel_q]) ? ENG_RD : ENG_IDLE;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        take      = 1'b0;
        unit_done = '0;
        bus_req   = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ch_dst[sel_q];
        mem_size  = ch_size[sel_q];
        mem_wdata = data_q;
        unique case (state)
            ENG_IDLE: take = |ch_req;
            ENG_REQ:  bus_req = 1'b1;
            ENG_RD: begin
                bus_req  = 1'b1;
                mem_re   = 1'b1;
                mem_addr = ch_src[sel_q];
            end
            ENG_WR: begin
                bus_req          = 1'b1;
                mem_we           = 1'b1;
                unit_done[sel_q] = 1'b1;
            end
            default: ;
        endcase
    end

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we}));

    // R12
    strobe_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (bus_req && bus_gnt));

    // R12
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    // R8
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ch_burst[sel_q] && !ch_last[sel_q]) |=> bus_req);

    // R7
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ch_burst[sel_q]) |=> !bus_req);

endmodule

// File: rtl/dma2_top.sv
module dma2_top
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        dreq,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [1:0]        irq,
    output logic [1:0]        err_flag,
    output logic [1:0]        busy
);

    localparam int NCH = 2;

    logic                       rr_q, pick, take;
    logic [NCH-1:0]             act, unit_done, burst_v, last_v;
    logic [NCH-1:0][ADDR_W-1:0] src_v, dst_v;
    logic [NCH-1:0][1:0]        size_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= 1'b0;
        else if (cfg_we && cfg_sel == REG_GLOBAL) rr_q <= cfg_wdata[0];
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        logic hit;
        assign hit = cfg_we && (cfg_ch == 1'(gi)) && (cfg_sel != REG_GLOBAL);
        dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (hit),
            .cfg_sel   (cfg_sel),
            .cfg_wdata (cfg_wdata),
            .dreq      (dreq[gi]),
            .unit_done (unit_done[gi]),
            .active    (act[gi]),
            .cur_src   (src_v[gi]),
            .cur_dst   (dst_v[gi]),
            .size      (size_v[gi]),
            .burst     (burst_v[gi]),
            .last      (last_v[gi]),
            .irq       (irq[gi]),
            .err_flag  (err_flag[gi])
        );
    end

    dma2_arb #(.NCH(NCH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (act),
        .rr_mode (rr_q),
        .take    (take),
        .pick    (pick)
    );

    dma2_eng #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_req    (act),
        .pick      (pick),
        .ch_src    (src_v),
        .ch_dst    (dst_v),
        .ch_size   (size_v),
        .ch_burst  (burst_v),
        .ch_last   (last_v),
        .bus_gnt   (bus_gnt),
        .mem_rdata (mem_rdata),
        .take      (take),
        .unit_done (unit_done),
        .bus_req   (bus_req),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata)
    );

    assign busy = act;

endmodule

// File: tb/tb_dma2_top.sv
module tb_dma2_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_ch = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  dreq = '0;
    logic        gnt_allow = 1'b1;
    logic        bus_gnt;
    logic [31:0] mem_rdata;
    logic        bus_req, mem_re, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size, irq, err_flag, busy;

    logic [7:0]  mem [256];
    logic [7:0]  log_a [16];
    int          log_n = 0, falls = 0, bad_strobe = 0;
    logic        breq_prev = 1'b0;
    int          n_chk = 0, n_fail = 0;
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_gnt = bus_req & gnt_allow;

    dma2_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dreq(dreq), .bus_gnt(bus_gnt), .mem_rdata(mem_rdata),
        .bus_req(bus_req), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .irq(irq), .err_flag(err_flag), .busy(busy)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 3 + 1);
    endfunction

    always_comb begin
        logic [7:0] a;
        a = mem_addr[7:0];
        mem_rdata = {mem[8'(a + 8'd3)], mem[8'(a + 8'd2)], mem[8'(a + 8'd1)], mem[a]};
    end

    // memory model: sources below 0x80 hold a pattern, destinations start at zero
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= (i < 128) ? pat(i) : 8'h00;
        end else if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata[7:0];
            if (mem_size != 2'd0) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
            if (mem_size >= 2'd2) begin
                mem[8'(mem_addr[7:0] + 8'd2)] <= mem_wdata[23:16];
                mem[8'(mem_addr[7:0] + 8'd3)] <= mem_wdata[31:24];
            end
        end
    end

    always @(posedge clk) begin
        breq_prev <= bus_req;
        if (rst_n && breq_prev && !bus_req) falls <= falls + 1;
        if (rst_n && (mem_re || mem_we) && !bus_gnt) bad_strobe <= bad_strobe + 1;
        if (rst_n && mem_we) begin
            log_a[log_n % 16] <= mem_addr[7:0];
            log_n <= log_n + 1;
        end
    end

    function automatic logic [31:0] rd32(input int a);
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic ch, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic ch, input int s, input int d, input int c, input int mode);
        wr(ch, 3'd0, 32'(s));
        wr(ch, 3'd1, 32'(d));
        wr(ch, 3'd2, 32'(c));
        wr(ch, 3'd3, 32'(mode));
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && busy != 2'b00; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 bus_req after reset", 32'(bus_req), 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 err after reset", 32'(err_flag), 32'd0);
        chk("R1 busy after reset", 32'(busy), 32'd0);
    endtask

    task automatic t_word_steal();
        int f0;
        f0 = falls;
        setup(1'b0, 'h00, 'h80, 3, 'h22); // word, irq enable
        wr(1'b0, 3'd4, 32'h1);
        chk("R11 software start busy", 32'(busy[0]), 32'd1);
        wait_idle();
        chk("R2 word 0", rd32('h80), {pat(3), pat(2), pat(1), pat(0)});
        chk("R2 word 3", rd32('h8C), {pat(15), pat(14), pat(13), pat(12)});
        chk("R5 no fifth word", rd32('h90), 32'h0);
        chk("R7 release per unit", 32'(falls - f0), 32'd4);
        chk("R10 irq on done", 32'(irq[0]), 32'd1);
        wr(1'b0, 3'd4, 32'h4);
        chk("R10 done cleared", 32'(irq[0]), 32'd0);
    endtask

    task automatic t_byte_single();
        setup(1'b1, 'h11, 'h91, 0, 'h00);
        wr(1'b1, 3'd4, 32'h1);
        wait_idle();
        chk("R5 count 0 one byte", 32'(mem['h91]), 32'(pat('h11)));
        chk("R5 count 0 stops", 32'(mem['h92]), 32'd0);
        chk("R2 byte leaves left", 32'(mem['h90]), 32'd0);
    endtask

    task automatic t_half_hold();
        int f0;
        f0 = falls;
        setup(1'b0, 'h20, 'hA0, 2, 'h11); // half, dst hold
        wr(1'b0, 3'd4, 32'h1);
        wait_idle();
        chk("R6 held dst last half", {16'h0, mem['hA1], mem['hA0]}, {16'h0, pat('h25), pat('h24)});
        chk("R6 held dst no spill", 32'(mem['hA2]), 32'd0);
        chk("R7 three releases", 32'(falls - f0), 32'd3);
        wr(1'b0, 3'd4, 32'h4);
    endtask

    task automatic t_burst();
        int f0;
        f0 = falls;
        setup(1'b1, 'h30, 'hB0, 3, 'h06); // word, burst
        wr(1'b1, 3'd4, 32'h1);
        wait_idle();
        chk("R8 single release", 32'(falls - f0), 32'd1);
        chk("R8 burst last word", rd32('hBC), {pat('h3F), pat('h3E), pat('h3D), pat('h3C)});
        wr(1'b1, 3'd4, 32'h4);
    endtask

    task automatic t_order(input logic rr, input int base, input logic [31:0] exp);
        int l0;
        wr(1'b0, 3'd5, 32'(rr));
        setup(1'b0, 'h40, base, 1, 'h40);       // byte, ext enable
        setup(1'b1, 'h48, base + 8, 1, 'h40);
        l0 = log_n;
        @(negedge clk); dreq = 2'b11;
        @(negedge clk);
        chk("R11 ext start both", 32'(busy), 32'd3);
        dreq = 2'b00;
        wait_idle();
        chk(rr ? "R4 round-robin order" : "R3 fixed order",
            {log_a[l0 % 16], log_a[(l0 + 1) % 16], log_a[(l0 + 2) % 16], log_a[(l0 + 3) % 16]}, exp);
        wr(1'b0, 3'd4, 32'h4);
        wr(1'b1, 3'd4, 32'h4);
    endtask

    task automatic t_error();
        int l0;
        l0 = log_n;
        setup(1'b0, 'h02, 'hE0, 0, 'h22);        // word, misaligned source
        wr(1'b0, 3'd4, 32'h1);
        repeat (4) @(negedge clk);
        chk("R9 err set", 32'(err_flag[0]), 32'd1);
        chk("R10 irq on err", 32'(irq[0]), 32'd1);
        chk("R9 no busy", 32'(busy[0]), 32'd0);
        wr(1'b0, 3'd0, 32'h4);                   // fix alignment, error still set
        wr(1'b0, 3'd4, 32'h1);
        repeat (4) @(negedge clk);
        chk("R9 start ignored while err", 32'(log_n - l0), 32'd0);
        chk("R9 dst untouched", rd32('hE0), 32'h0);
        wr(1'b0, 3'd4, 32'h2);
        chk("R9 err cleared", 32'(err_flag[0]), 32'd0);
        chk("R10 irq drops", 32'(irq[0]), 32'd0);
        setup(1'b1, 'h04, 'hE4, 0, 'h03);        // size code 3
        wr(1'b1, 3'd4, 32'h1);
        repeat (4) @(negedge clk);
        chk("R9 size 3 err", 32'(err_flag[1]), 32'd1);
        chk("R9 size 3 no write", 32'(log_n - l0), 32'd0);
        wr(1'b1, 3'd4, 32'h2);
    endtask

    task automatic t_mask();
        setup(1'b1, 'h50, 'hF0, 0, 'h02);        // word, irq masked
        wr(1'b1, 3'd4, 32'h1);
        wait_idle();
        chk("R2 masked run copies", rd32('hF0), {pat('h53), pat('h52), pat('h51), pat('h50)});
        chk("R10 masked irq low", 32'(irq[1]), 32'd0);
        wr(1'b1, 3'd3, 32'h22);
        chk("R10 unmask shows done", 32'(irq[1]), 32'd1);
        wr(1'b1, 3'd4, 32'h4);
        chk("R10 clear done", 32'(irq[1]), 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_steal();
        t_byte_single();
        t_half_hold();
        t_burst();
        t_order(1'b0, 'hC0, 32'hC0C1C8C9);
        t_order(1'b1, 'hD0, 32'hD0D8D1D9);
        t_error();
        t_mask();
        chk("R12 strobes only when granted", 32'(bad_strobe), 32'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule